// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps time of day and the calendar as a chain of packed-BCD counters. A one-cycle enable, asserted once per second, advances the seconds field. Each field that wraps carries into the next: seconds into minutes, minutes into hours, and midnight into both the day-of-month and the day-of-week. The day-of-month carries into the month, the month into the year, and the year into a two-digit century. The length of each month is derived from the current month and year. Every year divisible by four is treated as a leap year, which is correct up to year 2099.

A synchronous parallel load writes all eight fields in one cycle, which is how software sets the clock. A stop input freezes every field, in the way a stopped oscillator would. A separate 512 Hz enable drives a test output that toggles while test mode is on. All outputs are registered and change on the clock edge that samples the enable or load causing the change. Loading digits that are not valid BCD gives undefined results.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, date 01, month 01, year 00, century 00 and day-of-week 1, and the test output is 0.
- R2: A tick with stop low adds one to the BCD seconds (09 becomes 10). Seconds and minutes wrap 59 to 00 and carry. Hours count 00 to 23 and wrap to 00 at midnight.
- R3: At midnight the date wraps to 01 and the month advances after day 30 for months 04, 06, 09 and 11, and after day 31 for months 01, 03, 05, 07, 08, 10 and 12. Otherwise the date adds one.
- R4: In month 02 the last day is 29 when the BCD year is divisible by four (00, 12, 24, 96) and 28 otherwise.
- R5: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century. Century (6 bits, 00 to 39) wraps 39 to 00.
- R6: Day-of-week (3 bits, 1 to 7) adds one only at the midnight rollover and wraps 7 to 1.
- R7: A load writes all eight fields at the next edge and takes priority over a tick in the same cycle, so the loaded values are seen unincremented.
- R8: While stop is high a tick changes no field.
- R9: With test mode on and stop low, each 512 Hz enable pulse inverts the test output. With stop high the output holds. With test mode off the output is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-second advance enable |
| tick512_i | input | 1 | 512 Hz enable for the test output |
| stop_i | input | 1 | Freeze all counting when high |
| ftest_en_i | input | 1 | Test output mode enable |
| load_i | input | 1 | Parallel load strobe |
| ld_cent_i | input | 6 | Century to load (BCD) |
| ld_year_i | input | 8 | Year to load (BCD) |
| ld_month_i | input | 8 | Month to load (BCD) |
| ld_date_i | input | 8 | Date to load (BCD) |
| ld_dow_i | input | 3 | Day-of-week to load |
| ld_hour_i | input | 8 | Hours to load (BCD) |
| ld_min_i | input | 8 | Minutes to load (BCD) |
| ld_sec_i | input | 8 | Seconds to load (BCD) |
| cent_o | output | 6 | Century (BCD) |
| year_o | output | 8 | Year (BCD) |
| month_o | output | 8 | Month (BCD) |
| date_o | output | 8 | Date (BCD) |
| dow_o | output | 3 | Day-of-week |
| hour_o | output | 8 | Hours (BCD) |
| min_o | output | 8 | Minutes (BCD) |
| sec_o | output | 8 | Seconds (BCD) |
| ftest_o | output | 1 | Test toggle output |

## Verification
A parallel load and a one-second tick can arrive in the same cycle. A tick can also coincide with the stop input. The bench drives load and tick together in the same cycle, using a time one second before midnight. The load must win with no increment, so every field must equal the loaded value and the day-of-week must not advance. A tick issued under stop at 23:59:59 must leave every field frozen. The same tick after stop is released must produce the full rollover.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam logic [7:0] MON_FEB = 8'h02;

  function automatic logic [7:0] month_last_day(input logic [7:0] month, input logic leap);
    case (month)
      MON_FEB:                       month_last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11:    month_last_day = 8'h30;
      default:                       month_last_day = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr #(
  parameter int unsigned  W       = 8,
  parameter logic [W-1:0] FIRST   = '0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  localparam int unsigned HW = W - 4;

  logic [W-1:0] q_q, q_inc;

  always_comb begin
    if (q_q[3:0] == 4'h9) q_inc = {q_q[W-1:4] + HW'(1), 4'h0};
    else                  q_inc = {q_q[W-1:4], q_q[3:0] + 4'h1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= RST_VAL;
    else if (ld_i)  q_q <= ld_val_i;
    else if (inc_i) q_q <= (q_q == last_i) ? FIRST : q_inc;
  end

  assign carry_o = inc_i && (q_q == last_i);
  assign q_o     = q_q;
endmodule

// File: rtl/month_len.sv
module month_len
  import bcd_cal_pkg::*;
(
  input  logic [7:0] month_i,
  input  logic       yr_tens_lsb_i,
  input  logic [1:0] yr_ones_lo_i,
  output logic [7:0] last_day_o
);
  logic leap;
  // (10*t + u) mod 4 == (2*t[0] + u[1:0]) mod 4
  assign leap       = ~(yr_ones_lo_i[1] ^ yr_tens_lsb_i) & ~yr_ones_lo_i[0];
  assign last_day_o = month_last_day(month_i, leap);
endmodule

// File: rtl/ftest_toggle.sv
module ftest_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  input  logic pulse_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q_o <= 1'b0;
    else if (!en_i)            q_o <= 1'b0;
    else if (run_i && pulse_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int unsigned  CENT_W    = 6,
  parameter logic [7:0]   YEAR_LAST = 8'h99,
  parameter logic [7:0]   MON_LAST  = 8'h12,
  parameter logic [2:0]   DOW_LAST  = 3'd7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic              tick512_i,
  input  logic              stop_i,
  input  logic              ftest_en_i,
  input  logic              load_i,
  input  logic [CENT_W-1:0] ld_cent_i,
  input  logic [7:0]        ld_year_i,
  input  logic [7:0]        ld_month_i,
  input  logic [7:0]        ld_date_i,
  input  logic [2:0]        ld_dow_i,
  input  logic [7:0]        ld_hour_i,
  input  logic [7:0]        ld_min_i,
  input  logic [7:0]        ld_sec_i,
  output logic [CENT_W-1:0] cent_o,
  output logic [7:0]        year_o,
  output logic [7:0]        month_o,
  output logic [7:0]        date_o,
  output logic [2:0]        dow_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        min_o,
  output logic [7:0]        sec_o,
  output logic              ftest_o
);
  localparam int unsigned    N_HMS = 3;
  localparam logic [7:0]     HMS_LAST [N_HMS] = '{8'h59, 8'h59, 8'h23};
  localparam logic [CENT_W-1:0] CENT_LAST = CENT_W'(8'h39);

  logic [7:0]     hms_ld  [N_HMS];
  logic [7:0]     hms_q   [N_HMS];
  logic [N_HMS:0] hms_inc;
  logic [7:0]     last_day;
  logic           date_wrap, mon_wrap, year_wrap, unused_cent_wrap;
  logic [2:0]     dow_q;

  assign hms_inc[0] = sec_tick_i && !stop_i;
  assign hms_ld[0]  = ld_sec_i;
  assign hms_ld[1]  = ld_min_i;
  assign hms_ld[2]  = ld_hour_i;

  // seconds -> minutes -> hours
  for (genvar i = 0; i < N_HMS; i++) begin : g_hms
    bcd_field_ctr #(.W(8), .FIRST(8'h00), .RST_VAL(8'h00)) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (hms_inc[i]),
      .ld_i     (load_i),
      .ld_val_i (hms_ld[i]),
      .last_i   (HMS_LAST[i]),
      .q_o      (hms_q[i]),
      .carry_o  (hms_inc[i+1])
    );
  end

  month_len u_mlen (
    .month_i       (month_o),
    .yr_tens_lsb_i (year_o[4]),
    .yr_ones_lo_i  (year_o[1:0]),
    .last_day_o    (last_day)
  );

  bcd_field_ctr #(.W(8), .FIRST(8'h01), .RST_VAL(8'h01)) u_date (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(hms_inc[N_HMS]), .ld_i(load_i),
    .ld_val_i(ld_date_i), .last_i(last_day), .q_o(date_o), .carry_o(date_wrap)
  );

  bcd_field_ctr #(.W(8), .FIRST(8'h01), .RST_VAL(8'h01)) u_month (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(date_wrap), .ld_i(load_i),
    .ld_val_i(ld_month_i), .last_i(MON_LAST), .q_o(month_o), .carry_o(mon_wrap)
  );

  bcd_field_ctr #(.W(8), .FIRST(8'h00), .RST_VAL(8'h00)) u_year (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(mon_wrap), .ld_i(load_i),
    .ld_val_i(ld_year_i), .last_i(YEAR_LAST), .q_o(year_o), .carry_o(year_wrap)
  );

  bcd_field_ctr #(.W(CENT_W), .FIRST('0), .RST_VAL('0)) u_cent (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(year_wrap), .ld_i(load_i),
    .ld_val_i(ld_cent_i), .last_i(CENT_LAST), .q_o(cent_o), .carry_o(unused_cent_wrap)
  );

  // day-of-week runs free of the date, advancing at midnight only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dow_q <= 3'd1;
    else if (load_i)            dow_q <= ld_dow_i;
    else if (hms_inc[N_HMS])    dow_q <= (dow_q == DOW_LAST) ? 3'd1 : dow_q + 3'd1;
  end

  ftest_toggle u_ftest (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ftest_en_i),
    .run_i   (!stop_i),
    .pulse_i (tick512_i),
    .q_o     (ftest_o)
  );

  assign sec_o  = hms_q[0];
  assign min_o  = hms_q[1];
  assign hour_o = hms_q[2];
  assign dow_o  = dow_q;
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sec_tick_i,
  input logic       stop_i,
  input logic       ftest_en_i,
  input logic       load_i,
  input logic [7:0] ld_sec_i,
  input logic [2:0] ld_dow_i,
  input logic [5:0] cent_o,
  input logic [7:0] year_o,
  input logic [7:0] month_o,
  input logic [7:0] date_o,
  input logic [2:0] dow_o,
  input logic [7:0] hour_o,
  input logic [7:0] min_o,
  input logic [7:0] sec_o,
  input logic       ftest_o
);
  logic midnight;
  assign midnight = sec_tick_i && !stop_i && !load_i &&
                    hour_o == 8'h23 && min_o == 8'h59 && sec_o == 8'h59;

  // R8
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> $stable({cent_o, year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o}));

  // R7
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sec_o == $past(ld_sec_i) && dow_o == $past(ld_dow_i)));

  // R6
  dow_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    midnight |=> dow_o == (($past(dow_o) == 3'd7) ? 3'd1 : $past(dow_o) + 3'd1));

  // R6
  dow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!midnight && !load_i) |=> $stable(dow_o));

  // R2
  sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && !stop_i && !load_i) |=> sec_o != $past(sec_o));

  // R9
  ftest_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ftest_en_i |=> !ftest_o);
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sec_tick_i(sec_tick_i), .stop_i(stop_i),
  .ftest_en_i(ftest_en_i), .load_i(load_i), .ld_sec_i(ld_sec_i), .ld_dow_i(ld_dow_i),
  .cent_o(cent_o), .year_o(year_o), .month_o(month_o), .date_o(date_o), .dow_o(dow_o),
  .hour_o(hour_o), .min_o(min_o), .sec_o(sec_o), .ftest_o(ftest_o)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 0, tick512 = 0, stop = 0, ftest_en = 0, load = 0;
  logic [5:0] ld_cent = '0;
  logic [7:0] ld_year = '0, ld_month = '0, ld_date = '0, ld_hour = '0, ld_min = '0, ld_sec = '0;
  logic [2:0] ld_dow = '0;
  logic [5:0] cent;
  logic [7:0] year, month, date, hour, mn, sec;
  logic [2:0] dow;
  logic       ftest;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  bcd_calendar u_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(sec_tick), .tick512_i(tick512),
    .stop_i(stop), .ftest_en_i(ftest_en), .load_i(load),
    .ld_cent_i(ld_cent), .ld_year_i(ld_year), .ld_month_i(ld_month), .ld_date_i(ld_date),
    .ld_dow_i(ld_dow), .ld_hour_i(ld_hour), .ld_min_i(ld_min), .ld_sec_i(ld_sec),
    .cent_o(cent), .year_o(year), .month_o(month), .date_o(date), .dow_o(dow),
    .hour_o(hour), .min_o(mn), .sec_o(sec), .ftest_o(ftest)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_all(input string tag, input logic [5:0] c, input logic [7:0] y,
                            input logic [7:0] mo, input logic [7:0] d, input logic [2:0] w,
                            input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    chk({tag, " century"}, 32'(cent), 32'(c));
    chk({tag, " year"},    32'(year), 32'(y));
    chk({tag, " month"},   32'(month), 32'(mo));
    chk({tag, " date"},    32'(date), 32'(d));
    chk({tag, " dow"},     32'(dow), 32'(w));
    chk({tag, " hour"},    32'(hour), 32'(h));
    chk({tag, " min"},     32'(mn), 32'(m));
    chk({tag, " sec"},     32'(sec), 32'(s));
  endtask

  task automatic set_ld(input logic [5:0] c, input logic [7:0] y, input logic [7:0] mo,
                        input logic [7:0] d, input logic [2:0] w, input logic [7:0] h,
                        input logic [7:0] m, input logic [7:0] s);
    ld_cent = c; ld_year = y; ld_month = mo; ld_date = d;
    ld_dow = w; ld_hour = h; ld_min = m; ld_sec = s;
  endtask

  task automatic do_load(input logic [5:0] c, input logic [7:0] y, input logic [7:0] mo,
                         input logic [7:0] d, input logic [2:0] w, input logic [7:0] h,
                         input logic [7:0] m, input logic [7:0] s);
    @(negedge clk);
    set_ld(c, y, mo, d, w, h, m, s);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic t_reset();
    expect_all("R1 reset", 6'h00, 8'h00, 8'h01, 8'h01, 3'd1, 8'h00, 8'h00, 8'h00);
    chk("R1 reset ftest", 32'(ftest), 32'd0);
  endtask

  task automatic t_hms();
    do_load(6'h20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h10, 8'h20, 8'h09);
    one_tick();
    expect_all("R2 sec 09->10", 6'h20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h10, 8'h20, 8'h10);
    do_load(6'h20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h13, 8'h59, 8'h59);
    one_tick();
    expect_all("R2 min carry", 6'h20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h14, 8'h00, 8'h00);
    do_load(6'h20, 8'h24, 8'h06, 8'h15, 3'd3, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_all("R2 midnight", 6'h20, 8'h24, 8'h06, 8'h16, 3'd4, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_month_len();
    do_load(6'h20, 8'h21, 8'h04, 8'h30, 3'd2, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_all("R3 apr 30", 6'h20, 8'h21, 8'h05, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00);
    do_load(6'h20, 8'h21, 8'h05, 8'h30, 3'd2, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_all("R3 may 30", 6'h20, 8'h21, 8'h05, 8'h31, 3'd3, 8'h00, 8'h00, 8'h00);
    do_load(6'h20, 8'h21, 8'h01, 8'h31, 3'd2, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_all("R3 jan 31", 6'h20, 8'h21, 8'h02, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00);
    do_load(6'h20, 8'h21, 8'h11, 8'h30, 3'd2, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_all("R3 nov 30", 6'h20, 8'h21, 8'h12, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic feb_case(input string tag, input logic [7:0] y, input logic [7:0] d,
                          input logic [7:0] emo, input logic [7:0] ed);
    do_load(6'h20, y, 8'h02, d, 3'd5, 8'h23, 8'h59, 8'h59);
    one_tick();
    chk({tag, " month"}, 32'(month), 32'(emo));
    chk({tag, " date"},  32'(date),  32'(ed));
  endtask

  task automatic t_feb();
    feb_case("R4 y24 28", 8'h24, 8'h28, 8'h02, 8'h29);
    feb_case("R4 y24 29", 8'h24, 8'h29, 8'h03, 8'h01);
    feb_case("R4 y23 28", 8'h23, 8'h28, 8'h03, 8'h01);
    feb_case("R4 y00 28", 8'h00, 8'h28, 8'h02, 8'h29);
    feb_case("R4 y12 28", 8'h12, 8'h28, 8'h02, 8'h29);
    feb_case("R4 y14 28", 8'h14, 8'h28, 8'h03, 8'h01);
    feb_case("R4 y96 28", 8'h96, 8'h28, 8'h02, 8'h29);
    feb_case("R4 y98 28", 8'h98, 8'h28, 8'h03, 8'h01);
  endtask

  task automatic t_year();
    do_load(6'h20, 8'h41, 8'h12, 8'h31, 3'd6, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_all("R5 new year", 6'h20, 8'h42, 8'h01, 8'h01, 3'd7, 8'h00, 8'h00, 8'h00);
    do_load(6'h20, 8'h99, 8'h12, 8'h31, 3'd6, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_all("R5 century", 6'h21, 8'h00, 8'h01, 8'h01, 3'd7, 8'h00, 8'h00, 8'h00);
    do_load(6'h39, 8'h99, 8'h12, 8'h31, 3'd6, 8'h23, 8'h59, 8'h59);
    one_tick();
    expect_all("R5 cent wrap", 6'h00, 8'h00, 8'h01, 8'h01, 3'd7, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_dow();
    do_load(6'h20, 8'h30, 8'h03, 8'h10, 3'd7, 8'h23, 8'h59, 8'h59);
    one_tick();
    chk("R6 dow 7->1", 32'(dow), 32'd1);
    do_load(6'h20, 8'h30, 8'h03, 8'h10, 3'd4, 8'h12, 8'h59, 8'h59);
    one_tick();
    chk("R6 dow hold midday", 32'(dow), 32'd4);
    chk("R6 hour 13", 32'(hour), 32'h13);
  endtask

  task automatic t_load_tick();
    @(negedge clk);
    set_ld(6'h20, 8'h50, 8'h07, 8'h04, 3'd2, 8'h23, 8'h59, 8'h59);
    load = 1'b1;
    sec_tick = 1'b1;
    @(negedge clk);
    load = 1'b0;
    sec_tick = 1'b0;
    expect_all("R7 load beats tick", 6'h20, 8'h50, 8'h07, 8'h04, 3'd2, 8'h23, 8'h59, 8'h59);
  endtask

  task automatic t_stop();
    do_load(6'h20, 8'h50, 8'h12, 8'h31, 3'd2, 8'h23, 8'h59, 8'h59);
    @(negedge clk);
    stop = 1'b1;
    one_tick();
    one_tick();
    expect_all("R8 stopped", 6'h20, 8'h50, 8'h12, 8'h31, 3'd2, 8'h23, 8'h59, 8'h59);
    stop = 1'b0;
    one_tick();
    expect_all("R8 resumed", 6'h20, 8'h51, 8'h01, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic pulse512();
    @(negedge clk);
    tick512 = 1'b1;
    @(negedge clk);
    tick512 = 1'b0;
  endtask

  task automatic t_ftest();
    @(negedge clk);
    ftest_en = 1'b1;
    @(negedge clk);
    chk("R9 enabled idle", 32'(ftest), 32'd0);
    pulse512();
    chk("R9 toggle 1", 32'(ftest), 32'd1);
    pulse512();
    chk("R9 toggle 2", 32'(ftest), 32'd0);
    pulse512();
    chk("R9 toggle 3", 32'(ftest), 32'd1);
    stop = 1'b1;
    pulse512();
    chk("R9 hold on stop", 32'(ftest), 32'd1);
    stop = 1'b0;
    @(negedge clk);
    ftest_en = 1'b0;
    @(negedge clk);
    chk("R9 disabled low", 32'(ftest), 32'd0);
    pulse512();
    chk("R9 disabled pulse", 32'(ftest), 32'd0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hms();
    t_month_len();
    t_feb();
    t_year();
    t_dow();
    t_load_tick();
    t_stop();
    t_ftest();
    report();
  end
endmodule